// File: doc/BRIEF.md
# Operand Address Generator

This unit works out where an operand lives for a 16-bit processor. For each operand the decoder hands it a mode field, a register number and that register's contents, and a size. It also hands over the address at which the optional extension word sits, and whether the operand is a source or a destination. Some modes need an extension word. For those, the unit asks the fetch logic for the word and waits until it arrives. It then presents one result for one cycle. The result holds the effective address, the immediate value when there is one, and whether a memory read is needed. It also says whether an extension word was used, and which register gets written back with what value.

The control is a three-state machine. In IDLE the unit is ready. A start pulse captures the request. It moves to FETCH when the mode needs an extension word, and to DONE otherwise. In FETCH it raises a request for the word. When the word arrives (ext_valid) it captures it and moves to DONE. DONE presents the result for one cycle and always returns to IDLE. A start pulse is ignored outside IDLE.

Mode codes on `mode`:

| Code | Mode |
|------|------|
| 0 | register |
| 1 | indexed |
| 2 | symbolic (PC-relative) |
| 3 | absolute |
| 4 | indirect |
| 5 | indirect with post-increment |
| 6 | immediate |
| 7 | reserved |

Size codes on `size`:

| Code | Size |
|------|------|
| 00 | word (the default) |
| 01 | byte |
| 10 | address |
| 11 | word |

Top module: `opaddr_gen`

## Requirements
- R1: After reset, `ready` is 1, and `done` and `ext_req` are 0.
- R2: Register mode (code 0): `done` rises in the cycle after start. It comes with `mem_rd`=0, `ext_used`=0, `wb_en`=0, `imm`=0 and `ea`=0.
- R3: Indexed mode (code 1): `ea` = extension word + `rn_val`, modulo 2^16, with `mem_rd`=1 and `ext_used`=1. It is legal for destinations.
- R4: Symbolic mode (code 2): `ea` = `pc_ext` + extension word, modulo 2^16, with `mem_rd`=1 and `ext_used`=1.
- R5: Absolute mode (code 3): `ea` = the extension word, with `mem_rd`=1 and `ext_used`=1.
- R6: Indirect mode (code 4): `ea` = `rn_val`, with `mem_rd`=1, `wb_en`=0 and no extension word. `done` rises in the cycle after start.
- R7: Post-increment mode (code 5): `ea` = `rn_val`, with `mem_rd`=1, `wb_en`=1 and `wb_idx`=`rn`. `wb_val` is `rn_val`+1 when size is 01, and `rn_val`+2 for any other size. Both sums wrap modulo 2^16.
- R8: Immediate mode (code 6): `imm`=1, `imm_val` = the extension word, `mem_rd`=0 and `ext_used`=1. The program counter (register 0) is written back, so `wb_idx`=0, and `wb_val` = `pc_ext`+2. `ea` = `pc_ext`.
- R9: An illegal request gives `illegal`=1 with `mem_rd`, `wb_en`, `ext_used`, `imm` all 0 and `ea`=0. No extension word is requested, and `done` rises in the cycle after start. A request is illegal when it is a destination (`is_dst`=1) in mode 4, 5 or 6, or when it uses mode 7.
- R10: In FETCH, `ext_req` stays at 1 until a cycle with `ext_valid`=1. `done` follows in the next cycle.
- R11: A start pulse while `ready`=0 is ignored. The result is the one for the request captured earlier.
- R12: `done` lasts exactly one cycle, and `ready` is 1 in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, taken only while ready |
| is_dst | input | 1 | 1 = destination operand |
| mode | input | 3 | Addressing mode code |
| rn | input | RW | Register number |
| rn_val | input | DW | Contents of the register |
| pc_ext | input | DW | Address of the extension word |
| size | input | 2 | Operand size code |
| ext_valid | input | 1 | Extension word present on ext_data |
| ext_data | input | DW | Extension word |
| ready | output | 1 | Unit idle, accepts start |
| ext_req | output | 1 | Extension word requested |
| done | output | 1 | Result valid (one cycle) |
| ea | output | DW | Effective address |
| imm_val | output | DW | Immediate operand value |
| imm | output | 1 | Operand is immediate |
| mem_rd | output | 1 | Operand must be read from memory |
| ext_used | output | 1 | One extension word consumed |
| wb_en | output | 1 | Register write-back needed |
| wb_idx | output | RW | Register to write back |
| wb_val | output | DW | Write-back value |
| illegal | output | 1 | Mode not allowed for this operand |

## Verification
The bench builds the unit with its default widths: a 16-bit datapath (DW=16) and a 4-bit register index (RW=4). The 16-bit width means small operand values can drive the indexed sum, the symbolic sum and the post-increment step across the 0xFFFF boundary. Every reserved and destination-only combination of mode and operand side can also be tried. The bench varies how long the extension word takes to arrive, and it pulses start while a fetch is pending. This exercises the FETCH wait loop and the rule that start is ignored while busy.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;

    typedef enum logic [2:0] {
        AM_REG = 3'd0,
        AM_IDX = 3'd1,
        AM_SYM = 3'd2,
        AM_ABS = 3'd3,
        AM_IND = 3'd4,
        AM_INC = 3'd5,
        AM_IMM = 3'd6,
        AM_RSV = 3'd7
    } amode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_DONE  = 2'd2
    } ost_e;

    localparam logic [1:0] SZ_BYTE = 2'b01;

    // Destinations accept only the first four modes; code 7 is never legal.
    function automatic logic mode_legal(amode_e m, logic dst);
        case (m)
            AM_REG, AM_IDX, AM_SYM, AM_ABS: mode_legal = 1'b1;
            AM_IND, AM_INC, AM_IMM:         mode_legal = !dst;
            default:                        mode_legal = 1'b0;
        endcase
    endfunction

    function automatic logic mode_ext(amode_e m, logic dst);
        mode_ext = mode_legal(m, dst) &&
                   (m == AM_IDX || m == AM_SYM || m == AM_ABS || m == AM_IMM);
    endfunction

endpackage

// File: rtl/opaddr_calc.sv
module opaddr_calc
    import opaddr_pkg::*;
#(
    parameter int DW     = 16,
    parameter int RW     = 4,
    parameter int PC_IDX = 0
) (
    input  amode_e          mode,
    input  logic            is_dst,
    input  logic [RW-1:0]   rn,
    input  logic [DW-1:0]   rn_val,
    input  logic [DW-1:0]   pc_ext,
    input  logic [1:0]      size,
    input  logic [DW-1:0]   ext_data,
    output logic [DW-1:0]   ea,
    output logic [DW-1:0]   imm_val,
    output logic            imm,
    output logic            mem_rd,
    output logic            ext_used,
    output logic            wb_en,
    output logic [RW-1:0]   wb_idx,
    output logic [DW-1:0]   wb_val,
    output logic            illegal
);
    localparam logic [DW-1:0] STEP_B = DW'(1);
    localparam logic [DW-1:0] STEP_W = DW'(2);
    localparam logic [RW-1:0] PC_REG = RW'(PC_IDX);

    logic          legal;
    logic [DW-1:0] step;

    assign legal = mode_legal(mode, is_dst);
    assign step  = (size == SZ_BYTE) ? STEP_B : STEP_W;

    always_comb begin
        ea       = '0;
        imm_val  = '0;
        imm      = 1'b0;
        mem_rd   = 1'b0;
        ext_used = 1'b0;
        wb_en    = 1'b0;
        wb_idx   = '0;
        wb_val   = '0;
        illegal  = !legal;
        if (legal) begin
            case (mode)
                AM_IDX: begin
                    ea       = ext_data + rn_val;
                    mem_rd   = 1'b1;
                    ext_used = 1'b1;
                end
                AM_SYM: begin
                    ea       = pc_ext + ext_data;
                    mem_rd   = 1'b1;
                    ext_used = 1'b1;
                end
                AM_ABS: begin
                    ea       = ext_data;
                    mem_rd   = 1'b1;
                    ext_used = 1'b1;
                end
                AM_IND: begin
                    ea     = rn_val;
                    mem_rd = 1'b1;
                end
                AM_INC: begin
                    ea     = rn_val;
                    mem_rd = 1'b1;
                    wb_en  = 1'b1;
                    wb_idx = rn;
                    wb_val = rn_val + step;
                end
                AM_IMM: begin
                    ea       = pc_ext;
                    imm      = 1'b1;
                    imm_val  = ext_data;
                    ext_used = 1'b1;
                    wb_en    = 1'b1;
                    wb_idx   = PC_REG;
                    wb_val   = pc_ext + STEP_W;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/opaddr_ctrl.sv
module opaddr_ctrl
    import opaddr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic need_ext,
    input  logic ext_valid,
    output logic ready,
    output logic ext_req,
    output logic done,
    output logic load,
    output logic ext_load
);
    ost_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = need_ext ? ST_FETCH : ST_DONE;
            ST_FETCH: if (ext_valid) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ready    = 1'b0;
        ext_req  = 1'b0;
        done     = 1'b0;
        load     = 1'b0;
        ext_load = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ready = 1'b1;
                load  = start;
            end
            ST_FETCH: begin
                ext_req  = 1'b1;
                ext_load = ext_valid;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/opaddr_gen.sv
module opaddr_gen
    import opaddr_pkg::*;
#(
    parameter int DW = 16,
    parameter int RW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          is_dst,
    input  logic [2:0]    mode,
    input  logic [RW-1:0] rn,
    input  logic [DW-1:0] rn_val,
    input  logic [DW-1:0] pc_ext,
    input  logic [1:0]    size,
    input  logic          ext_valid,
    input  logic [DW-1:0] ext_data,
    output logic          ready,
    output logic          ext_req,
    output logic          done,
    output logic [DW-1:0] ea,
    output logic [DW-1:0] imm_val,
    output logic          imm,
    output logic          mem_rd,
    output logic          ext_used,
    output logic          wb_en,
    output logic [RW-1:0] wb_idx,
    output logic [DW-1:0] wb_val,
    output logic          illegal
);
    logic          load, ext_load, need_ext;
    amode_e        mode_q;
    logic          dst_q;
    logic [RW-1:0] rn_q;
    logic [DW-1:0] rv_q, pc_q, ext_q;
    logic [1:0]    size_q;

    assign need_ext = mode_ext(amode_e'(mode), is_dst);

    opaddr_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .need_ext (need_ext),
        .ext_valid(ext_valid),
        .ready    (ready),
        .ext_req  (ext_req),
        .done     (done),
        .load     (load),
        .ext_load (ext_load)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= AM_REG;
            dst_q  <= 1'b0;
            rn_q   <= '0;
            rv_q   <= '0;
            pc_q   <= '0;
            size_q <= '0;
        end else if (load) begin
            mode_q <= amode_e'(mode);
            dst_q  <= is_dst;
            rn_q   <= rn;
            rv_q   <= rn_val;
            pc_q   <= pc_ext;
            size_q <= size;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ext_q <= '0;
        else if (ext_load) ext_q <= ext_data;
    end

    opaddr_calc #(.DW(DW), .RW(RW), .PC_IDX(0)) u_calc (
        .mode    (mode_q),
        .is_dst  (dst_q),
        .rn      (rn_q),
        .rn_val  (rv_q),
        .pc_ext  (pc_q),
        .size    (size_q),
        .ext_data(ext_q),
        .ea      (ea),
        .imm_val (imm_val),
        .imm     (imm),
        .mem_rd  (mem_rd),
        .ext_used(ext_used),
        .wb_en   (wb_en),
        .wb_idx  (wb_idx),
        .wb_val  (wb_val),
        .illegal (illegal)
    );

endmodule

// File: rtl/opaddr_gen_chk.sv
module opaddr_gen_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [2:0]    mode,
    input logic          ready,
    input logic          ext_req,
    input logic          ext_valid,
    input logic          done,
    input logic [DW-1:0] ea,
    input logic          mem_rd,
    input logic          ext_used,
    input logic          wb_en,
    input logic [DW-1:0] wb_val,
    input logic          illegal
);
    // R2 R6 R9
    no_ext_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ready && (mode == 3'd0 || mode == 3'd4 || mode == 3'd5 || mode == 3'd7)) |=> done);

    // R10
    ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req && !ext_valid) |=> ext_req);

    // R10
    ext_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req && ext_valid) |=> done);

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (ready && !done));

    // R9
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && illegal) |-> (!mem_rd && !wb_en && !ext_used));

    // R7
    wb_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && wb_en) |-> (wb_val == ea + DW'(1) || wb_val == ea + DW'(2)));

    // R11
    busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ext_req && ready));

endmodule

bind opaddr_gen opaddr_gen_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .mode     (mode),
    .ready    (ready),
    .ext_req  (ext_req),
    .ext_valid(ext_valid),
    .done     (done),
    .ea       (ea),
    .mem_rd   (mem_rd),
    .ext_used (ext_used),
    .wb_en    (wb_en),
    .wb_val   (wb_val),
    .illegal  (illegal)
);

// File: tb/opaddr_gen_bench.sv
module opaddr_gen_bench;
    localparam int DW = 16;
    localparam int RW = 4;

    typedef struct {
        string         tag;
        logic [DW-1:0] ea;
        logic [DW-1:0] imm_val;
        logic          imm;
        logic          mem_rd;
        logic          ext_used;
        logic          wb_en;
        logic [RW-1:0] wb_idx;
        logic [DW-1:0] wb_val;
        logic          illegal;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          is_dst = 1'b0;
    logic [2:0]    mode = '0;
    logic [RW-1:0] rn = '0;
    logic [DW-1:0] rn_val = '0;
    logic [DW-1:0] pc_ext = '0;
    logic [1:0]    size = '0;
    logic          ext_valid = 1'b0;
    logic [DW-1:0] ext_data = '0;
    logic          ready, ext_req, done, imm, mem_rd, ext_used, wb_en, illegal;
    logic [DW-1:0] ea, imm_val, wb_val;
    logic [RW-1:0] wb_idx;

    int   checks = 0;
    int   errors = 0;
    bit   finished = 1'b0;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    opaddr_gen #(.DW(DW), .RW(RW)) u_opaddr_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .is_dst(is_dst), .mode(mode),
        .rn(rn), .rn_val(rn_val), .pc_ext(pc_ext), .size(size),
        .ext_valid(ext_valid), .ext_data(ext_data), .ready(ready),
        .ext_req(ext_req), .done(done), .ea(ea), .imm_val(imm_val), .imm(imm),
        .mem_rd(mem_rd), .ext_used(ext_used), .wb_en(wb_en), .wb_idx(wb_idx),
        .wb_val(wb_val), .illegal(illegal)
    );

    task automatic chk(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic exp_t predict(string tag, logic [2:0] m, logic d, logic [RW-1:0] r,
                                     logic [DW-1:0] rv, logic [DW-1:0] pc, logic [1:0] sz,
                                     logic [DW-1:0] x);
        exp_t e;
        e.tag = tag; e.ea = '0; e.imm_val = '0; e.imm = 0; e.mem_rd = 0; e.ext_used = 0;
        e.wb_en = 0; e.wb_idx = '0; e.wb_val = '0; e.illegal = 0;
        if (m == 3'd7 || (d && m >= 3'd4)) e.illegal = 1;
        else case (m)
            3'd1: begin e.ea = x + rv; e.mem_rd = 1; e.ext_used = 1; end
            3'd2: begin e.ea = pc + x; e.mem_rd = 1; e.ext_used = 1; end
            3'd3: begin e.ea = x;      e.mem_rd = 1; e.ext_used = 1; end
            3'd4: begin e.ea = rv;     e.mem_rd = 1; end
            3'd5: begin e.ea = rv; e.mem_rd = 1; e.wb_en = 1; e.wb_idx = r;
                        e.wb_val = rv + ((sz == 2'b01) ? 16'd1 : 16'd2); end
            3'd6: begin e.ea = pc; e.imm = 1; e.imm_val = x; e.ext_used = 1;
                        e.wb_en = 1; e.wb_idx = '0; e.wb_val = pc + 16'd2; end
            default: ;
        endcase
        return e;
    endfunction

    // Driver: push the expected result, then play the request and the extension word.
    task automatic issue(string tag, logic [2:0] m, logic d, logic [RW-1:0] r,
                         logic [DW-1:0] rv, logic [DW-1:0] pc, logic [1:0] sz,
                         logic [DW-1:0] x, int delay, bit poke);
        bit needx;
        needx = !(m == 3'd7 || (d && m >= 3'd4)) && (m == 3'd1 || m == 3'd2 || m == 3'd3 || m == 3'd6);
        while (!ready) @(negedge clk);
        exp_q.push_back(predict(tag, m, d, r, rv, pc, sz, x));
        start = 1; mode = m; is_dst = d; rn = r; rn_val = rv; pc_ext = pc; size = sz;
        @(negedge clk);
        start = 0;
        if (needx) begin
            for (int i = 0; i < delay; i++) begin
                chk(ext_req === 1'b1, {tag, " R10 ext_req held"}, {15'd0, ext_req}, 16'd1);
                if (poke) begin
                    chk(ready === 1'b0, {tag, " R11 busy"}, {15'd0, ready}, 16'd0);
                    start = 1; mode = 3'd0; is_dst = 0; rn_val = 16'hDEAD; pc_ext = 16'hBEEF;
                end
                @(negedge clk);
                start = 0;
            end
            ext_valid = 1; ext_data = x;
            @(negedge clk);
            ext_valid = 0; ext_data = 16'h5A5A;
        end else begin
            chk(done === 1'b1, {tag, " done after one cycle"}, {15'd0, done}, 16'd1);
        end
    endtask

    // Monitor: compare each result against the scoreboard head.
    bit prev_done = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_done)
                chk(done === 1'b0 && ready === 1'b1, "R12 done single pulse",
                    {14'd0, done, ready}, 16'd1);
            if (done === 1'b1) begin
                if (exp_q.size() == 0) begin
                    chk(0, "unexpected done", 16'd1, 16'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(ea === e.ea, {e.tag, " ea"}, ea, e.ea);
                    chk(imm_val === e.imm_val && imm === e.imm, {e.tag, " imm"}, imm_val, e.imm_val);
                    chk(mem_rd === e.mem_rd && ext_used === e.ext_used && illegal === e.illegal,
                        {e.tag, " flags"}, {13'd0, mem_rd, ext_used, illegal},
                        {13'd0, e.mem_rd, e.ext_used, e.illegal});
                    chk(wb_en === e.wb_en && wb_idx === e.wb_idx && wb_val === e.wb_val,
                        {e.tag, " writeback"}, wb_val, e.wb_val);
                end
            end
            prev_done = done;
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(0, "watchdog expired", 16'd0, 16'd1);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(ready === 1'b1 && done === 1'b0 && ext_req === 1'b0, "R1 reset state",
            {13'd0, ready, done, ext_req}, 16'd4);
        rst_n = 1;
        @(negedge clk);
        issue("R2 register",        3'd0, 0, 4'd5, 16'h1234, 16'h0100, 2'b00, 16'h0,    0, 0);
        issue("R3 indexed wrap",    3'd1, 0, 4'd4, 16'h0020, 16'h0100, 2'b00, 16'hFFF0, 0, 0);
        issue("R3 indexed dst",     3'd1, 1, 4'd6, 16'h0200, 16'h0100, 2'b00, 16'h0004, 1, 0);
        issue("R4 symbolic",        3'd2, 0, 4'd0, 16'h0,    16'h8002, 2'b00, 16'h0100, 2, 0);
        issue("R5 absolute dst",    3'd3, 1, 4'd2, 16'h0,    16'h0300, 2'b01, 16'h0210, 0, 0);
        issue("R6 indirect",        3'd4, 0, 4'd7, 16'h0A00, 16'h0100, 2'b00, 16'h0,    0, 0);
        issue("R7 autoinc byte",    3'd5, 0, 4'd8, 16'h0A01, 16'h0100, 2'b01, 16'h0,    0, 0);
        issue("R7 autoinc word",    3'd5, 0, 4'd9, 16'h0A02, 16'h0100, 2'b00, 16'h0,    0, 0);
        issue("R7 autoinc address", 3'd5, 0, 4'd10, 16'h0B00, 16'h0100, 2'b10, 16'h0,   0, 0);
        issue("R7 autoinc size3",   3'd5, 0, 4'd11, 16'h0C00, 16'h0100, 2'b11, 16'h0,   0, 0);
        issue("R7 autoinc wrap",    3'd5, 0, 4'd15, 16'hFFFF, 16'h0100, 2'b01, 16'h0,   0, 0);
        issue("R8 immediate",       3'd6, 0, 4'd0, 16'h0,    16'hC00E, 2'b00, 16'h00E2, 3, 0);
        issue("R9 indirect dst",    3'd4, 1, 4'd5, 16'h0400, 16'h0100, 2'b00, 16'h0,    0, 0);
        issue("R9 autoinc dst",     3'd5, 1, 4'd5, 16'h0400, 16'h0100, 2'b00, 16'h0,    0, 0);
        issue("R9 immediate dst",   3'd6, 1, 4'd0, 16'h0,    16'h0100, 2'b00, 16'h7777, 0, 0);
        issue("R9 reserved",        3'd7, 0, 4'd5, 16'h0400, 16'h0100, 2'b00, 16'h0,    0, 0);
        issue("R11 start ignored",  3'd2, 0, 4'd0, 16'h0,    16'h4000, 2'b00, 16'h0123, 3, 1);
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R10 all results seen", 16'(exp_q.size()), 16'd0);
        summary();
    end

endmodule